// File: doc/BRIEF.md
# Nine-bit stored-program CPU

This block is a small multicycle processor. Instructions and data words are both 9 bits wide and share one 16-word memory. Four general-purpose registers, a program counter and an instruction register hold the state. Every instruction takes two cycles: a FETCH cycle that copies the word at the PC into the IR and steps the PC, then an EXEC cycle that carries out the operation. The top 3 bits of a word select one of eight operations. The remaining 6 bits hold either three 2-bit register fields or one register field and a 4-bit address. The address field can name a memory word, a port number, or a jump target.

The program and its data are written into memory through a preload port while reset is held. Releasing reset starts execution at address 0. A Write operation drives a register's value onto the output bus with a one-cycle strobe, and a Read operation takes the value on the input bus. Execution ends in a HALT state once the word at address 15 has executed without redirecting the PC.

The sequencer has three states. Reset leads to FETCH. FETCH always goes to EXEC. EXEC goes back to FETCH when a jump or taken branch redirects the PC, or when the PC has not wrapped. EXEC goes to HALT when the instruction it just ran came from address 15 and did not redirect. HALT leads only to itself until reset.

Top module: `nine_bit_cpu`

## Requirements
- R1: A synchronous reset clears the PC, the IR, all four registers and the output strobe, and puts the sequencer in FETCH with `halted` low. Memory keeps its contents.
- R2: Each instruction takes one FETCH cycle and one EXEC cycle. FETCH loads the IR from the word at the PC and sets PC to PC+1 modulo 16. The Write at the k-th instruction executed after reset release raises `out_valid` in cycle 2k+2, counting cycles from 0.
- R3: The opcode is word bits [8:6], with 000 Sub, 001 Add, 010 Load, 011 Store, 100 Read, 101 Write, 110 GoTo and 111 BranchIf. Register operations use destination [5:4], first source [3:2] and second source [1:0]. All other operations use register [5:4] and address [3:0].
- R4: Add writes first source + second source, and Sub writes first source − second source, into the destination register, both modulo 512.
- R5: Load copies the memory word at the address into the register. Store writes the register into that memory word.
- R6: Read copies `in_data` into the register. `io_sel` always shows bits [3:0] of the IR.
- R7: Write places the register on `out_data` and raises `out_valid` for exactly one cycle.
- R8: GoTo sets the PC to the address field.
- R9: BranchIf sets the PC to the address field when the register is nonzero. When the register is zero, the PC keeps its incremented value.
- R10: When the word fetched from address 15 executes without redirecting the PC, the sequencer enters HALT. While halted, `halted` stays high, no further instruction executes and `out_valid` stays low until reset.
- R11: `pre_we` writes `pre_data` into word `pre_addr` only while reset is asserted. It has no effect while the CPU runs.
- R12: A program that loads word 4 (holding 5) into R2, reads 7 into R3, computes R1 = R3 − R2 and stores R1 into word 5 leaves 2 in word 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables preload |
| pre_we | input | 1 | Preload write enable, honoured during reset only |
| pre_addr | input | 4 | Preload word address |
| pre_data | input | 9 | Preload word value |
| in_data | input | 9 | Input bus sampled by Read |
| io_sel | output | 4 | Port number (address field of the IR) |
| out_data | output | 9 | Value driven by the latest Write |
| out_valid | output | 1 | One-cycle strobe for a Write |
| halted | output | 1 | High in the HALT state |

## Verification
Reset is released between clock edges. The first rising edge after release ends FETCH of word 0, and the second ends its EXEC. A Write therefore shows `out_valid` after the second edge, and each further instruction in line adds two edges. `halted` rises after the EXEC edge of the last instruction that ran. A behavioural reference model in the bench steps on the same rising edges, mirroring the fetch, execute and halt phases. Its expected values are compared with the ports at every falling edge, so each result is checked in the exact cycle it is due. Each program also checks its output values and strobe cycles against hand-computed lists.

// File: rtl/cpu9_pkg.sv
package cpu9_pkg;

    typedef enum logic [2:0] {
        OP_SUB   = 3'b000,
        OP_ADD   = 3'b001,
        OP_LOAD  = 3'b010,
        OP_STORE = 3'b011,
        OP_READ  = 3'b100,
        OP_WRITE = 3'b101,
        OP_GOTO  = 3'b110,
        OP_BRIF  = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } state_e;

endpackage

// File: rtl/cpu9_alu.sv
module cpu9_alu #(
    parameter int DW = 9
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          do_sub,
    output logic [DW-1:0] res
);
    // Natural DW-bit arithmetic gives the modulo-2^DW wrap.
    assign res = do_sub ? (opa - opb) : (opa + opb);
endmodule

// File: rtl/cpu9_regfile.sv
module cpu9_regfile #(
    parameter int DW  = 9,
    parameter int RAW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd,
    input  logic [RAW-1:0] ra_a,
    input  logic [RAW-1:0] ra_b,
    input  logic [RAW-1:0] ra_c,
    output logic [DW-1:0]  rd_a,
    output logic [DW-1:0]  rd_b,
    output logic [DW-1:0]  rd_c
);
    localparam int NREG = 1 << RAW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wa == RAW'(i))
                regs[i] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];

    AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(wa)] == $past(wd))); // R4
endmodule

// File: rtl/cpu9_mem.sv
module cpu9_mem #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[wa] <= wd;
    end

    assign rd = cells[ra];
endmodule

// File: rtl/nine_bit_cpu.sv
module nine_bit_cpu
    import cpu9_pkg::*;
#(
    parameter int DW  = 9,
    parameter int AW  = 4,
    parameter int RAW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic [DW-1:0] in_data,
    output logic [AW-1:0] io_sel,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          halted
);
    localparam int            OPW     = DW - AW - RAW;
    localparam logic [AW-1:0] LAST_PC = '1;

    state_e        state, nxt;
    logic [AW-1:0] pc;
    logic [DW-1:0] ir;
    logic          wrap;

    // instruction fields
    opcode_e        op;
    logic [RAW-1:0] f_dst, f_src1, f_src2;
    logic [AW-1:0]  f_addr;

    assign op     = opcode_e'(ir[DW-1 -: OPW]);
    assign f_dst  = ir[AW+RAW-1 -: RAW];
    assign f_src1 = ir[2*RAW-1 -: RAW];
    assign f_src2 = ir[RAW-1:0];
    assign f_addr = ir[AW-1:0];

    // datapath nets
    logic [DW-1:0] src1_val, src2_val, dst_val, alu_res, mem_rd, rf_wd;
    logic          rf_we, mem_we, alu_sub, jump, wr_stb;
    logic          mem_wen;
    logic [AW-1:0] mem_wa, mem_ra;
    logic [DW-1:0] mem_wd;

    cpu9_regfile #(.DW(DW), .RAW(RAW)) u_rf (
        .clk (clk),     .rst (rst),
        .we  (rf_we),   .wa  (f_dst),   .wd (rf_wd),
        .ra_a(f_src1),  .ra_b(f_src2),  .ra_c(f_dst),
        .rd_a(src1_val),.rd_b(src2_val),.rd_c(dst_val)
    );

    cpu9_alu #(.DW(DW)) u_alu (
        .opa(src1_val), .opb(src2_val), .do_sub(alu_sub), .res(alu_res)
    );

    // Preload owns the write port while reset is held.
    assign mem_wen = rst ? pre_we   : mem_we;
    assign mem_wa  = rst ? pre_addr : f_addr;
    assign mem_wd  = rst ? pre_data : dst_val;
    assign mem_ra  = (state == ST_EXEC) ? f_addr : pc;

    cpu9_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .we(mem_wen), .wa(mem_wa), .wd(mem_wd),
        .ra (mem_ra), .rd(mem_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_FETCH;
        else
            state <= nxt;
    end

    // next state and execute decode
    always_comb begin
        nxt     = state;
        rf_we   = 1'b0;
        rf_wd   = alu_res;
        mem_we  = 1'b0;
        alu_sub = 1'b0;
        jump    = 1'b0;
        wr_stb  = 1'b0;
        unique case (state)
            ST_FETCH: nxt = ST_EXEC;
            ST_EXEC: begin
                unique case (op)
                    OP_SUB:   begin rf_we = 1'b1; alu_sub = 1'b1; end
                    OP_ADD:   rf_we = 1'b1;
                    OP_LOAD:  begin rf_we = 1'b1; rf_wd = mem_rd; end
                    OP_STORE: mem_we = 1'b1;
                    OP_READ:  begin rf_we = 1'b1; rf_wd = in_data; end
                    OP_WRITE: wr_stb = 1'b1;
                    OP_GOTO:  jump = 1'b1;
                    OP_BRIF:  jump = |dst_val;
                    default:  ;
                endcase
                if (jump)
                    nxt = ST_FETCH;
                else if (wrap)
                    nxt = ST_HALT;
                else
                    nxt = ST_FETCH;
            end
            ST_HALT: nxt = ST_HALT;
            default: nxt = ST_FETCH;
        endcase
    end

    // PC, IR and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            ir        <= '0;
            wrap      <= 1'b0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= wr_stb;
            if (wr_stb)
                out_data <= dst_val;
            if (state == ST_FETCH) begin
                ir   <= mem_rd;
                pc   <= pc + 1'b1;
                wrap <= (pc == LAST_PC);
            end else if (state == ST_EXEC && jump) begin
                pc   <= f_addr;
                wrap <= 1'b0;
            end
        end
    end

    assign io_sel = f_addr;
    assign halted = (state == ST_HALT);

    AST_FETCH_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_EXEC)); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (pc == AW'($past(pc) + 1'b1))); // R2
    AST_GOTO_TARGET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && op == OP_GOTO) |=> (pc == $past(f_addr))); // R8
    AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && op == OP_BRIF && dst_val == '0) |=> (pc == $past(pc))); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R7
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !out_valid)); // R10
endmodule

// File: tb/tb_nine_bit_cpu.sv
module tb_nine_bit_cpu;
    localparam int CLK_PERIOD = 10;

    typedef int img_t [16];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [8:0] pre_data = '0;
    logic [8:0] in_data = '0;
    logic [3:0] io_sel;
    logic [8:0] out_data;
    logic       out_valid;
    logic       halted;

    nine_bit_cpu dut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .in_data(in_data), .io_sel(io_sel),
        .out_data(out_data), .out_valid(out_valid), .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_since = 0;
    bit live = 0;

    // behavioural reference machine
    int m_mem [16];
    int m_reg [4];
    int m_pc, m_ir, m_phase, m_data;
    bit m_wrap, m_valid;

    int got_val [$];
    int got_cyc [$];

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rrr(int op, int d, int s1, int s2);
        return (op << 6) | (d << 4) | (s1 << 2) | s2;
    endfunction

    function automatic int rad(int op, int r, int a);
        return (op << 6) | (r << 4) | a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            if (pre_we) m_mem[pre_addr] = int'(pre_data);
            m_pc = 0; m_ir = 0; m_phase = 0; m_wrap = 0; m_valid = 0; m_data = 0;
            for (int i = 0; i < 4; i++) m_reg[i] = 0;
            cyc_since = 0;
        end else begin
            cyc_since = cyc_since + 1;
            m_valid = 0;
            if (m_phase == 0) begin
                m_ir = m_mem[m_pc];
                m_wrap = (m_pc == 15);
                m_pc = (m_pc + 1) % 16;
                m_phase = 1;
            end else if (m_phase == 1) begin
                int op, d, s1, s2, a, t;
                bit jmp;
                op = (m_ir >> 6) & 7; d = (m_ir >> 4) & 3;
                s1 = (m_ir >> 2) & 3; s2 = m_ir & 3; a = m_ir & 15;
                jmp = 0;
                case (op)
                    0: begin t = (m_reg[s1] - m_reg[s2] + 512) % 512; m_reg[d] = t; end
                    1: begin t = (m_reg[s1] + m_reg[s2]) % 512; m_reg[d] = t; end
                    2: m_reg[d] = m_mem[a];
                    3: m_mem[a] = m_reg[d];
                    4: m_reg[d] = int'(in_data);
                    5: begin m_valid = 1; m_data = m_reg[d]; end
                    6: jmp = 1;
                    default: jmp = (m_reg[d] != 0);
                endcase
                if (jmp) begin m_pc = a; m_wrap = 0; m_phase = 0; end
                else m_phase = m_wrap ? 2 : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R10 halted vs model", int'(halted), int'(m_phase == 2));
            chk("R7 out_valid vs model", int'(out_valid), int'(m_valid));
            if (m_valid) chk("R7 out_data vs model", int'(out_data), m_data);
            chk("R6 io_sel vs model", int'(io_sel), m_ir & 15);
            if (out_valid) begin
                got_val.push_back(int'(out_data));
                got_cyc.push_back(cyc_since);
            end
        end
    end

    task automatic run_prog(input img_t img, input int inval, input bit poke);
        rst = 1'b1; live = 0; in_data = 9'(inval);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = 4'(i); pre_data = 9'(img[i]);
        end
        @(negedge clk); pre_we = 1'b0;
        @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 halted in reset", int'(halted), 0);
        chk("R1 io_sel in reset", int'(io_sel), 0);
        got_val.delete(); got_cyc.delete();
        rst = 1'b0; live = 1;
        if (poke) begin pre_we = 1'b1; pre_addr = 4'd12; pre_data = 9'd77; end
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk("R10 halt reached", int'(halted), 1);
        repeat (12) @(negedge clk);
        chk("R10 halt sticky", int'(halted), 1);
        pre_we = 1'b0; live = 0;
    endtask

    task automatic expect_out(string tag, int exp [$]);
        chk({tag, " write count"}, got_val.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got_val.size(); i++)
            chk({tag, " write value"}, got_val[i], exp[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        img_t p;
        for (int i = 0; i < 16; i++) m_mem[i] = 0;

        // R12, R5, R3: sample program with Load/Read/Sub/Store, readback via Write
        p = '{default: 0};
        p[0] = rad(2, 2, 4); p[1] = rad(4, 3, 14); p[2] = rrr(0, 1, 3, 2);
        p[3] = rad(3, 1, 5); p[4] = 5; p[6] = rad(2, 0, 5);
        p[7] = rad(5, 0, 15); p[8] = rad(5, 1, 15);
        run_prog(p, 7, 0);
        expect_out("R12", '{2, 2});

        // R1, R2: registers cleared by reset, strobe cycles 2, 4, 6
        p = '{default: 0};
        p[0] = rad(5, 1, 0); p[1] = rad(5, 2, 0); p[2] = rad(5, 3, 0);
        run_prog(p, 0, 0);
        expect_out("R1", '{0, 0, 0});
        chk("R2 strobe count", got_cyc.size(), 3);
        for (int i = 0; i < 3 && i < got_cyc.size(); i++)
            chk("R2 strobe cycle", got_cyc[i], 2 * i + 2);

        // R4: add wraps 300+300 -> 88, sub 0-300 -> 212
        p = '{default: 0};
        p[0] = rad(4, 1, 3); p[1] = rrr(1, 3, 1, 1); p[2] = rad(5, 3, 9);
        p[3] = rrr(0, 0, 2, 1); p[4] = rad(5, 0, 9);
        run_prog(p, 300, 0);
        expect_out("R4", '{88, 212});

        // R8, R9: taken branch, fall-through branch, GoTo
        p = '{default: 0};
        p[0] = rad(4, 1, 0); p[1] = rad(7, 1, 4); p[2] = rad(5, 1, 0);
        p[4] = rad(7, 2, 7); p[5] = rad(5, 1, 0); p[6] = rad(6, 0, 9);
        p[7] = rad(5, 2, 0); p[8] = rad(5, 2, 0);
        p[9] = rrr(1, 3, 1, 1); p[10] = rad(5, 3, 0);
        run_prog(p, 1, 0);
        expect_out("R9", '{1, 2});

        // R11, R10: preload writes while running are ignored; word 15 executes, then halt
        p = '{default: 0};
        p[0] = rad(2, 1, 12); p[1] = rad(5, 1, 0); p[2] = rad(6, 0, 13);
        p[12] = 33; p[13] = rad(5, 1, 0); p[15] = rad(5, 1, 0);
        run_prog(p, 0, 1);
        expect_out("R11", '{33, 33, 33});

        // R10: taken branch at word 15 avoids halt; later fall-through halts
        p = '{default: 0};
        p[0] = rad(4, 1, 0); p[1] = rad(6, 0, 15); p[13] = rad(5, 1, 0);
        p[14] = rrr(0, 1, 1, 1); p[15] = rad(7, 1, 13);
        run_prog(p, 5, 0);
        expect_out("R10", '{5});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule